// File: doc/BRIEF.md
# DMA Address Translation Unit with Page-Cache Invalidation

This block converts 32-bit DMA bus addresses into physical addresses. It looks each 4 KB page up in a single-level table in memory. The table has one 32-bit word per page: bit 31 marks the word as valid, and bits [19:0] hold the physical page number. A small fully associative cache of four recent entries answers repeated lookups without a memory access. On a cache miss the unit reads the table word over a simple one-beat read port. The unit serves one request at a time.

Software sets the unit up through a small register port. Register 1 holds the table base and register 2 holds the table size, both counted in pages. Register 0 holds the enable bit and two self-clearing commands: one drops every cached entry, and the other drops the entry for one page index. Software writes a command bit and then polls it until it reads zero. Requesters that can drive wide addresses may use a bypass window at and above address 0x80_0000_0000. In that window the address goes straight through with its top bit removed.

Top module: `iommu_xlate`

## Requirements
- R1: After reset, the enable bit and both command bits read 0, the cache is empty, `rsp_valid` and `mem_req` are low, and `req_ready` is high.
- R2: While the enable bit (register 0, bit 31) is clear, every accepted request gets an error response one cycle after it is accepted, and no table read is made.
- R3: On a cache miss, `mem_req` pulses for one cycle, starting one cycle after the request is accepted. `mem_addr` carries base×4096 + index×4, where the index is bus address bits [31:12]. The response comes one cycle after `mem_rvalid`.
- R4: A valid table word gives `rsp_addr` = {8'b0, word[19:0], bus address[11:0]} with `rsp_err` low.
- R5: A table word with bit 31 clear gives an error response with `rsp_addr` zero. That word is not cached, so a repeated access reads the table again.
- R6: An index at or above size×1024 gives an error response and no table read. The size register keeps only its low 10 bits of a write.
- R7: A cached page gives its response one cycle after acceptance, and no table read is made.
- R8: The cache holds four entries and replaces them in round-robin order. After four distinct fills, a fifth fill evicts the oldest entry.
- R9: Writing register 0 with bit 30 set makes bit 30 read 1 for exactly one cycle. Bit 30 then reads 0, and by then every cached entry has been dropped.
- R10: Writing register 0 with bit 29 set and a page index in bits [19:0] makes bit 29 read 1 for one cycle. Only the cached entry for that index is dropped.
- R11: With `req_bypass` high and address bit 39 set, the response is the address with bit 39 cleared, and no table read is made. Any other request with address bits [39:32] non-zero gets an error response.
- R12: `req_ready` is low while a table read is outstanding and while either command bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 base, 2 size |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (control reads {en, flush, inv, 29'b0}) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 40 | Bus address |
| req_bypass | input | 1 | Requester may use the bypass window |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_addr | output | 40 | Physical address |
| mem_req | output | 1 | Table word read pulse |
| mem_addr | output | 32 | Byte address of the table word |
| mem_rvalid | input | 1 | Table word returned |
| mem_rdata | input | 32 | Table word |

## Verification
The translation path is driven with first-time accesses to valid pages, repeat accesses, and pages whose table word is invalid. These separate the fetch path, the cache-hit path and the no-fill rule for invalid words. Indices just under and just over the programmed size, together with an oversized size write, show where the range limit sits and that the size register is masked. A sequence of five distinct pages is run after a flush, and then one page is invalidated. This shows that round-robin eviction, a full flush and a single-entry invalidate each drop exactly the entries they should. Bypass, upper-bit and disabled-unit requests confirm that no table read is made when none is due.

// File: rtl/iommu_pkg.sv
package iommu_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 40;
    localparam int PAGE_SHIFT = 12;
    localparam int RPN_W      = 20;
    localparam int SIZE_W     = 10;
    localparam int TLB_N      = 4;
    localparam int DATA_W     = 32;
    localparam int MA_W       = 32;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_BASE = 2'd1;
    localparam logic [1:0] REG_SIZE = 2'd2;

    localparam int BIT_EN    = 31;
    localparam int BIT_FLUSH = 30;
    localparam int BIT_INV   = 29;
    localparam int BIT_PTE_V = 31;

    typedef enum logic {ST_IDLE, ST_WAIT} walk_state_e;
    typedef enum logic [1:0] {LK_ERR, LK_DONE, LK_WALK} lookup_e;

    function automatic logic pte_valid(input logic [DATA_W-1:0] w);
        return w[BIT_PTE_V];
    endfunction

    function automatic logic [RPN_W-1:0] pte_rpn(input logic [DATA_W-1:0] w);
        return w[RPN_W-1:0];
    endfunction
endpackage

// File: rtl/iommu_regs.sv
module iommu_regs
    import iommu_pkg::*;
#(
    parameter int IDX_W  = VA_W - PAGE_SHIFT,
    parameter int BASE_W = RPN_W,
    parameter int SZ_W   = SIZE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              en,
    output logic              flush_pend,
    output logic              inv_pend,
    output logic [IDX_W-1:0]  inv_idx,
    output logic [BASE_W-1:0] base,
    output logic [SZ_W-1:0]   size
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en         <= 1'b0;
            flush_pend <= 1'b0;
            inv_pend   <= 1'b0;
            inv_idx    <= '0;
            base       <= '0;
            size       <= '0;
        end else begin
            if (flush_pend) flush_pend <= 1'b0;
            if (inv_pend)   inv_pend   <= 1'b0;
            if (reg_we) begin
                case (reg_addr)
                    REG_CTRL: begin
                        en <= reg_wdata[BIT_EN];
                        if (reg_wdata[BIT_FLUSH]) flush_pend <= 1'b1;
                        if (reg_wdata[BIT_INV]) begin
                            inv_pend <= 1'b1;
                            inv_idx  <= reg_wdata[IDX_W-1:0];
                        end
                    end
                    REG_BASE: base <= reg_wdata[BASE_W-1:0];
                    REG_SIZE: size <= reg_wdata[SZ_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = {en, flush_pend, inv_pend, {(DATA_W-3){1'b0}}};
            REG_BASE: reg_rdata = DATA_W'(base);
            REG_SIZE: reg_rdata = DATA_W'(size);
            default:  reg_rdata = '0;
        endcase
    end

    // R9: a pending flush that is not rewritten is gone one cycle later
    p_flush_selfclear_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_pend && !(reg_we && reg_addr == REG_CTRL && reg_wdata[BIT_FLUSH])) |=> !flush_pend);
    // R10: same for the single-entry command
    p_inv_selfclear_r10: assert property (@(posedge clk) disable iff (rst)
        (inv_pend && !(reg_we && reg_addr == REG_CTRL && reg_wdata[BIT_INV])) |=> !inv_pend);
endmodule

// File: rtl/iommu_tlb.sv
module iommu_tlb
    import iommu_pkg::*;
#(
    parameter int N     = TLB_N,
    parameter int IDX_W = VA_W - PAGE_SHIFT,
    parameter int RW    = RPN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             hit,
    output logic [RW-1:0]    hit_rpn,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [RW-1:0]    fill_rpn,
    input  logic             flush,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     vld, vld_next, hit_vec, inv_vec;
    logic [IDX_W-1:0] tag [N];
    logic [RW-1:0]    rpn [N];
    logic [PTR_W-1:0] ptr;
    logic             fill_ok;

    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            assign hit_vec[i] = vld[i] && (tag[i] == lk_idx);
            assign inv_vec[i] = vld[i] && (tag[i] == inv_idx);
        end
    endgenerate

    always_comb begin
        hit_rpn = '0;
        for (int i = 0; i < N; i++)
            if (hit_vec[i]) hit_rpn = hit_rpn | rpn[i];
    end
    assign hit = |hit_vec;

    assign fill_ok = fill_en && !flush && !(inv_en && inv_idx == fill_idx);

    always_comb begin
        vld_next = vld;
        if (inv_en) vld_next = vld_next & ~inv_vec;
        if (fill_ok) vld_next[ptr] = 1'b1;
        if (flush) vld_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            ptr <= '0;
        end else begin
            vld <= vld_next;
            if (fill_ok) ptr <= (ptr == PTR_W'(N-1)) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_ok) begin
            tag[ptr] <= fill_idx;
            rpn[ptr] <= fill_rpn;
        end
    end

    // R8: tags stay unique, so at most one entry matches
    p_hit_unique_r8: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
    // R9: a flush leaves nothing cached
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst) flush |=> (vld == '0));
endmodule

// File: rtl/iommu_xlate.sv
module iommu_xlate
    import iommu_pkg::*;
#(
    parameter int VW    = VA_W,
    parameter int PW    = PA_W,
    parameter int PSH   = PAGE_SHIFT,
    parameter int RW    = RPN_W,
    parameter int SW    = SIZE_W,
    parameter int NENT  = TLB_N,
    parameter int DW    = DATA_W,
    parameter int AW    = MA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [PW-1:0] req_addr,
    input  logic          req_bypass,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [PW-1:0] rsp_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    localparam int IDX_W     = VW - PSH;
    localparam int ENT_SHIFT = PSH - 2;

    logic              en, flush_pend, inv_pend;
    logic [IDX_W-1:0]  inv_idx, idx, cur_idx;
    logic [RW-1:0]     base, hit_rpn;
    logic [SW-1:0]     size;
    logic [IDX_W:0]    lim;
    logic [PSH-1:0]    cur_off;
    logic              hit, in_range, hi_zero, byp_win, accept, fill_en;
    walk_state_e       state;
    lookup_e           lk;

    iommu_regs #(.IDX_W(IDX_W), .BASE_W(RW), .SZ_W(SW)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en(en),
        .flush_pend(flush_pend), .inv_pend(inv_pend), .inv_idx(inv_idx),
        .base(base), .size(size)
    );

    assign idx      = req_addr[PSH +: IDX_W];
    assign lim      = (IDX_W+1)'(size) << ENT_SHIFT;
    assign in_range = {1'b0, idx} < lim;
    assign hi_zero  = (req_addr[PW-1:VW] == '0);
    assign byp_win  = req_bypass && req_addr[PW-1];
    assign req_ready = (state == ST_IDLE) && !flush_pend && !inv_pend;
    assign accept   = req_valid && req_ready;
    assign fill_en  = (state == ST_WAIT) && mem_rvalid && pte_valid(mem_rdata);

    iommu_tlb #(.N(NENT), .IDX_W(IDX_W), .RW(RW)) u_tlb (
        .clk(clk), .rst(rst), .lk_idx(idx), .hit(hit), .hit_rpn(hit_rpn),
        .fill_en(fill_en), .fill_idx(cur_idx), .fill_rpn(pte_rpn(mem_rdata)),
        .flush(flush_pend), .inv_en(inv_pend), .inv_idx(inv_idx)
    );

    always_comb begin
        if (!en)                   lk = LK_ERR;
        else if (byp_win)          lk = LK_DONE;
        else if (!hi_zero)         lk = LK_ERR;
        else if (!in_range)        lk = LK_ERR;
        else if (hit)              lk = LK_DONE;
        else                       lk = LK_WALK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_addr  <= '0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            cur_idx   <= '0;
            cur_off   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            mem_req   <= 1'b0;
            if (state == ST_IDLE) begin
                if (accept) begin
                    case (lk)
                        LK_ERR: begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_addr  <= '0;
                        end
                        LK_DONE: begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b0;
                            rsp_addr  <= byp_win ? {1'b0, req_addr[PW-2:0]}
                                                 : PW'({hit_rpn, req_addr[PSH-1:0]});
                        end
                        default: begin
                            state    <= ST_WAIT;
                            mem_req  <= 1'b1;
                            mem_addr <= AW'({base, {PSH{1'b0}}}) + AW'({idx, 2'b00});
                            cur_idx  <= idx;
                            cur_off  <= req_addr[PSH-1:0];
                        end
                    endcase
                end
            end else if (mem_rvalid) begin
                state     <= ST_IDLE;
                rsp_valid <= 1'b1;
                rsp_err   <= !pte_valid(mem_rdata);
                rsp_addr  <= pte_valid(mem_rdata) ? PW'({pte_rpn(mem_rdata), cur_off}) : '0;
            end
        end
    end

    // R2: no table read is started by a disabled unit
    p_no_walk_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> $past(en));
    // R5: an error response never carries an address
    p_err_no_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_addr == '0));
    // R12: nothing is accepted while a walk is outstanding
    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !req_ready);
    // R3: a read pulse is followed by the waiting state
    p_walk_waits_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (state == ST_WAIT && !rsp_valid));
endmodule

// File: tb/iommu_xlate_bench.sv
module iommu_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [39:0] req_addr = '0;
    logic        req_bypass = 1'b0;
    logic        rsp_valid, rsp_err;
    logic [39:0] rsp_addr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    iommu_xlate u_iommu_xlate (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_bypass(req_bypass),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_fail = 0, n_fetch = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- table memory ----------------
    logic [31:0] tbl [int];
    bit          pend = 0;
    logic [31:0] pend_addr;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = tbl.exists(int'(pend_addr)) ? tbl[int'(pend_addr)] : 32'h0;
            pend = 0;
        end
        if (mem_req) begin
            pend = 1;
            pend_addr = mem_addr;
        end
    end

    // ---------------- reference model ----------------
    bit          m_en, m_fp, m_ip, m_wait, fl, iv, do_fill;
    int          m_inv, m_base, m_size, ividx, idx, hs, fidx, frpn;
    int          m_tag [4];
    int          m_rpn [4];
    bit          m_v   [4];
    int          m_ptr;
    logic [39:0] m_cur;
    bit          e_rv, e_err, e_mreq;
    logic [39:0] e_pa;
    logic [31:0] e_maddr;
    string       e_tag;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_fp = 0; m_ip = 0; m_wait = 0; m_inv = 0; m_base = 0; m_size = 0; m_ptr = 0;
            for (int i = 0; i < 4; i++) m_v[i] = 0;
            e_rv = 0; e_err = 0; e_mreq = 0; e_pa = '0; e_maddr = '0; e_tag = "R1";
        end else begin
            fl = m_fp; iv = m_ip; ividx = m_inv; do_fill = 0;
            e_rv = 0; e_mreq = 0;
            if (!m_wait && !m_fp && !m_ip && req_valid) begin
                idx = int'(req_addr[31:12]);
                e_rv = 1; e_err = 0; e_pa = '0;
                if (!m_en) begin e_err = 1; e_tag = "R2"; end
                else if (req_bypass && req_addr[39]) begin
                    e_pa = req_addr; e_pa[39] = 1'b0; e_tag = "R11";
                end
                else if (req_addr[39:32] != 0) begin e_err = 1; e_tag = "R11"; end
                else if (idx >= m_size * 1024) begin e_err = 1; e_tag = "R6"; end
                else begin
                    hs = -1;
                    for (int s = 0; s < 4; s++) if (m_v[s] && m_tag[s] == idx) hs = s;
                    if (hs >= 0) begin
                        e_pa = {8'h0, m_rpn[hs][19:0], req_addr[11:0]}; e_tag = "R7";
                    end else begin
                        e_rv = 0; e_mreq = 1; m_wait = 1; m_cur = req_addr;
                        e_maddr = 32'(m_base * 4096 + idx * 4);
                    end
                end
            end else if (m_wait && mem_rvalid) begin
                m_wait = 0; e_rv = 1; e_pa = '0;
                fidx = int'(m_cur[31:12]);
                if (!mem_rdata[31]) begin e_err = 1; e_tag = "R5"; end
                else begin
                    e_err = 0; e_tag = "R4";
                    e_pa = {8'h0, mem_rdata[19:0], m_cur[11:0]};
                    frpn = int'(mem_rdata[19:0]);
                    do_fill = !fl && !(iv && ividx == fidx);
                end
            end
            if (iv) for (int s = 0; s < 4; s++) if (m_v[s] && m_tag[s] == ividx) m_v[s] = 0;
            if (do_fill) begin
                m_tag[m_ptr] = fidx; m_rpn[m_ptr] = frpn; m_v[m_ptr] = 1;
                m_ptr = (m_ptr + 1) % 4;
            end
            if (fl) for (int s = 0; s < 4; s++) m_v[s] = 0;
            if (fl) m_fp = 0;
            if (iv) m_ip = 0;
            if (reg_we) begin
                case (reg_addr)
                    2'd0: begin
                        m_en = reg_wdata[31];
                        if (reg_wdata[30]) m_fp = 1;
                        if (reg_wdata[29]) begin m_ip = 1; m_inv = int'(reg_wdata[19:0]); end
                    end
                    2'd1: m_base = int'(reg_wdata[19:0]);
                    2'd2: m_size = int'(reg_wdata[9:0]);
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return {m_en, m_fp, m_ip, 29'b0};
            2'd1: return 32'(m_base);
            2'd2: return 32'(m_size);
            default: return 32'h0;
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        cyc++;
        if (!rst) begin
            if (mem_req) n_fetch++;
            chk(rsp_valid == e_rv, e_rv ? e_tag : "R3", 64'(rsp_valid), 64'(e_rv));
            if (e_rv) begin
                chk(rsp_err == e_err, e_tag, 64'(rsp_err), 64'(e_err));
                chk(rsp_addr == e_pa, e_tag, 64'(rsp_addr), 64'(e_pa));
            end
            chk(mem_req == e_mreq, "R3", 64'(mem_req), 64'(e_mreq));
            if (e_mreq) chk(mem_addr == e_maddr, "R3", 64'(mem_addr), 64'(e_maddr));
            chk(req_ready == (!m_wait && !m_fp && !m_ip), "R12", 64'(req_ready), 64'(!m_wait && !m_fp && !m_ip));
            chk(reg_rdata == exp_rdata(reg_addr), "R9", 64'(reg_rdata), 64'(exp_rdata(reg_addr)));
        end
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    endtask

    task automatic xlate(input logic [39:0] a, input bit byp,
                         output bit err, output logic [39:0] pa, output bit fetched);
        int f0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        f0 = n_fetch;
        req_valid = 1'b1; req_addr = a; req_bypass = byp;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        err = rsp_err; pa = rsp_addr;
        #1;
        fetched = (n_fetch != f0);
    endtask

    localparam logic [31:0] EN = 32'h8000_0000;
    localparam int TB_BASE = 32'h100;

    function automatic int waddr(input int i);
        return TB_BASE * 4096 + i * 4;
    endfunction

    bit          e, f;
    logic [39:0] p;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1: reset state
        chk(req_ready == 1'b1, "R1", 64'(req_ready), 64'd1);
        chk(reg_rdata == 32'h0, "R1", 64'(reg_rdata), 64'd0);
        chk(rsp_valid == 1'b0 && mem_req == 1'b0, "R1", 64'({rsp_valid, mem_req}), 64'd0);

        // table contents
        tbl[waddr(5)]     = 32'h8000_0000 | 32'hABCDE;
        tbl[waddr(7)]     = 32'h0000_1234;
        tbl[waddr(10)]    = 32'h8000_0010;
        tbl[waddr(11)]    = 32'h8000_0011;
        tbl[waddr(12)]    = 32'h8000_0012;
        tbl[waddr(13)]    = 32'h8000_0013;
        tbl[waddr(32'h3FF)] = 32'h8000_0777;

        // R2: disabled unit
        xlate(40'h0000_5123, 0, e, p, f);
        chk(e && !f, "R2", 64'({e, f}), 64'b10);

        wr(2'd1, TB_BASE);
        wr(2'd2, 32'h401);          // R6: masked to 1 page of entries
        wr(2'd0, EN);

        // R3/R4 miss then R7 hit
        xlate(40'h0000_5123, 0, e, p, f);
        chk(!e && f && p == 40'hAB_CDE1_23, "R4", 64'(p), 64'hABCDE123);
        xlate(40'h0000_5FFF, 0, e, p, f);
        chk(!e && !f && p == 40'hAB_CDEF_FF, "R7", 64'({f, p}), 64'hABCDEFFF);

        // R5: invalid word, not cached
        xlate(40'h0000_7000, 0, e, p, f);
        chk(e && f && p == 0, "R5", 64'({e, f}), 64'b11);
        xlate(40'h0000_7000, 0, e, p, f);
        chk(e && f, "R5", 64'({e, f}), 64'b11);

        // R6: range edges
        xlate(40'h003F_F004, 0, e, p, f);
        chk(!e && p == 40'h77_7004, "R6", 64'(p), 64'h777004);
        xlate(40'h0040_0000, 0, e, p, f);
        chk(e && !f, "R6", 64'({e, f}), 64'b10);

        // R9: flush polling and effect
        wr(2'd0, EN | 32'h4000_0000);
        #1;
        chk(reg_rdata[30] == 1'b1, "R9", 64'(reg_rdata[30]), 64'd1);
        @(negedge clk); #1;
        chk(reg_rdata[30] == 1'b0, "R9", 64'(reg_rdata[30]), 64'd0);
        xlate(40'h0000_5000, 0, e, p, f);
        chk(!e && f, "R9", 64'(f), 64'd1);

        // R8: round robin over four entries (5 already in)
        xlate(40'h0000_A000, 0, e, p, f);
        xlate(40'h0000_B000, 0, e, p, f);
        xlate(40'h0000_C000, 0, e, p, f);
        xlate(40'h0000_D000, 0, e, p, f);   // evicts page 5
        xlate(40'h0000_B008, 0, e, p, f);
        chk(!f && p == 40'h11008, "R8", 64'({f, p}), 64'h11008);
        xlate(40'h0000_5000, 0, e, p, f);   // refetch, evicts page A
        chk(f, "R8", 64'(f), 64'd1);

        // R10: single-entry invalidate of page C
        wr(2'd0, EN | 32'h2000_0000 | 32'hC);
        #1;
        chk(reg_rdata[29] == 1'b1, "R10", 64'(reg_rdata[29]), 64'd1);
        xlate(40'h0000_B000, 0, e, p, f);
        chk(!f, "R10", 64'(f), 64'd0);
        xlate(40'h0000_C000, 0, e, p, f);
        chk(f && p == 40'h12000, "R10", 64'({f, p}), 64'h1_0001_2000);

        // R11: bypass window
        xlate(40'h80_1234_5678, 1, e, p, f);
        chk(!e && !f && p == 40'h00_1234_5678, "R11", 64'(p), 64'h12345678);
        xlate(40'h80_1234_5678, 0, e, p, f);
        chk(e && !f, "R11", 64'({e, f}), 64'b10);
        xlate(40'h01_0000_5000, 1, e, p, f);
        chk(e && !f, "R11", 64'({e, f}), 64'b10);

        // R2: disabling blocks even cached pages
        wr(2'd0, 32'h0);
        xlate(40'h0000_B000, 0, e, p, f);
        chk(e && !f, "R2", 64'({e, f}), 64'b10);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule